// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter with Break Monitor

This block serialises bytes onto an idle-high line, one bit per baud tick. A frame is a low start bit, eight data bits least significant first, an optional ninth bit, and one high stop bit. A one-entry holding register sits in front of the shift register. When buffering is on, software can load the next character while the current one is still on the wire. The next frame then follows after exactly one stop bit. The transmit interrupt moves to the moment the holding register frees up, and the ninth bit is captured together with the byte.

When buffering is off, the block acts as a plain single-buffered transmitter. In that case the interrupt fires at the start of the stop bit, and the ninth bit is read live at its own bit slot. A small monitor watches the receive line at each baud tick. It raises a sticky break flag after a long run of low samples.

The mode field works as follows. `00` selects the synchronous shift mode, where buffering is forced off. `01` selects 8-bit asynchronous frames. `10` and `11` select 9-bit asynchronous frames.

Top module: `dbuf_uart_tx`

## Requirements
- R1: The line idles high. A frame is a 0 start bit, then data bits 0 to 7 in that order, then a 1 stop bit. Each bit occupies one baud-tick period, and the line changes only on a clock edge where `baud_tick` is high.
- R2: With `mode_sel` 10 or 11, a ninth bit is inserted between data bit 7 and the stop bit.
- R3: With buffering active, a character written during the current frame starts its own start bit in the slot right after that frame's single stop bit.
- R4: With buffering active, `tx_irq` sets on the edge where the shift register takes the character out of the holding register. That is the edge on which the start bit appears.
- R5: With buffering active, the ninth bit sent is the value of `bit9_in` at the write strobe. Later changes to `bit9_in` have no effect on that frame.
- R6: With buffering off, the ninth bit sent is the value of `bit9_in` at the tick that begins the ninth-bit slot.
- R7: With buffering off, `tx_irq` sets on the edge where the stop bit begins. It is 0 during the data bits, and it stays 1 until `irq_clr` is pulsed.
- R8: Some writes are not accepted. With buffering on, this is a write while the holding register is full. With buffering off, it is a write while a character is waiting or being sent. Such a write is dropped and never transmitted, and it sets `tx_ovr`, which stays set until `ovr_clr`.
- R9: With `mode_sel` 00, buffering is off whatever `dbuf_en` says. The interrupt comes at the stop bit, and a write during a frame is refused.
- R10: `brk_flag` sets after 11 consecutive low samples of `rx_line`, taken at baud ticks. Ten low samples followed by a high one leave it clear.
- R11: `brk_clr` clears `brk_flag`. It does not set again until a high sample has been seen, followed by a fresh run of 11 lows.
- R12: After reset, `txd` is 1, and `tx_irq`, `tx_ovr` and `brk_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| mode_sel | input | 2 | 00 shift, 01 8-bit, 1x 9-bit |
| dbuf_en | input | 1 | Holding-register enable |
| wr_stb | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to send |
| bit9_in | input | 1 | Ninth data bit |
| irq_clr | input | 1 | Clears the transmit interrupt |
| ovr_clr | input | 1 | Clears the overrun flag |
| brk_clr | input | 1 | Clears the break flag |
| rx_line | input | 1 | Receive line being monitored |
| txd | output | 1 | Serial output |
| tx_irq | output | 1 | Sticky transmit interrupt |
| tx_ovr | output | 1 | Sticky overrun flag |
| brk_flag | output | 1 | Sticky break flag |

## Verification
The assertions assume that `baud_tick` is a single-cycle pulse spaced several clocks apart. They also assume that `mode_sel` and `dbuf_en` do not change while a frame is in flight. The bench drives ticks from a free-running divider of eight clocks. It changes the mode and enable only after the line has gone idle. The live ninth-bit case relies on `bit9_in` being held from the write until after its slot, and the stimulus keeps to that. `rx_line` is changed only on falling clock edges, so each tick samples a settled value.

// File: rtl/dbuf_uart_pkg.sv
package dbuf_uart_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_NINTH = 3'd3,
        ST_STOP  = 3'd4
    } tx_state_e;

    localparam logic [1:0] MODE_SHIFT  = 2'b00;
    localparam logic [1:0] MODE_ASYNC8 = 2'b01;

    localparam int DEF_DATA_W    = 8;
    localparam int DEF_BREAK_LEN = 11;

endpackage

// File: rtl/dbt_hold.sv
module dbt_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic [DW-1:0] wr_data,
    input  logic          ninth_in,
    input  logic          dbuf_on,
    input  logic          busy,
    input  logic          take,
    input  logic          ovr_clr,
    output logic          full,
    output logic [DW-1:0] data,
    output logic          ninth,
    output logic          ovr
);

    typedef struct packed {
        logic [DW-1:0] data;
        logic          ninth;
        logic          full;
        logic          ovr;
    } hold_s;

    hold_s h_d, h_q;
    logic  room;

    always_comb begin
        h_d  = h_q;
        // buffered: a slot exists if empty or being drained this cycle
        room = dbuf_on ? (!h_q.full || take) : (!h_q.full && !busy);
        if (wr_stb && room) begin
            h_d.data  = wr_data;
            h_d.ninth = ninth_in;
            h_d.full  = 1'b1;
        end else if (take) begin
            h_d.full = 1'b0;
        end
        if (wr_stb && !room) begin
            h_d.ovr = 1'b1;
        end else if (ovr_clr) begin
            h_d.ovr = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign full  = h_q.full;
    assign data  = h_q.data;
    assign ninth = h_q.ninth;
    assign ovr   = h_q.ovr;

    // R8: buffered write into a full, undrained slot is refused and flagged
    p_full_write_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && h_q.full && !take && dbuf_on) |=> h_q.ovr);

    // R8: a write to an empty register while the shifter is idle is kept
    p_idle_write_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !h_q.full && !busy) |=> h_q.full);

endmodule

// File: rtl/dbt_shift.sv
module dbt_shift
    import dbuf_uart_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          hold_full,
    input  logic [DW-1:0] hold_data,
    input  logic          hold_ninth,
    input  logic          ninth_live,
    input  logic          nine_mode,
    input  logic          dbuf_on,
    output logic          take,
    output logic          busy,
    output logic          stop_entry,
    output logic          txd
);

    localparam int IDXW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(DW - 1);

    typedef struct packed {
        tx_state_e     st;
        logic [DW-1:0] sh;
        logic          nin;
        logic [IDXW-1:0] idx;
        logic          txd;
    } shift_s;

    shift_s s_d, s_q;

    always_comb begin
        s_d        = s_q;
        take       = 1'b0;
        stop_entry = 1'b0;
        if (tick) begin
            unique case (s_q.st)
                ST_IDLE: begin
                    if (hold_full) begin
                        take    = 1'b1;
                        s_d.st  = ST_START;
                        s_d.sh  = hold_data;
                        s_d.nin = hold_ninth;
                        s_d.txd = 1'b0;
                    end
                end
                ST_START: begin
                    s_d.st  = ST_DATA;
                    s_d.idx = '0;
                    s_d.txd = s_q.sh[0];
                    s_d.sh  = s_q.sh >> 1;
                end
                ST_DATA: begin
                    if (s_q.idx != LAST_IDX) begin
                        s_d.idx = s_q.idx + 1'b1;
                        s_d.txd = s_q.sh[0];
                        s_d.sh  = s_q.sh >> 1;
                    end else if (nine_mode) begin
                        s_d.st  = ST_NINTH;
                        s_d.txd = dbuf_on ? s_q.nin : ninth_live;
                    end else begin
                        s_d.st     = ST_STOP;
                        s_d.txd    = 1'b1;
                        stop_entry = 1'b1;
                    end
                end
                ST_NINTH: begin
                    s_d.st     = ST_STOP;
                    s_d.txd    = 1'b1;
                    stop_entry = 1'b1;
                end
                ST_STOP: begin
                    if (hold_full) begin
                        take    = 1'b1;
                        s_d.st  = ST_START;
                        s_d.sh  = hold_data;
                        s_d.nin = hold_ninth;
                        s_d.txd = 1'b0;
                    end else begin
                        s_d.st  = ST_IDLE;
                        s_d.txd = 1'b1;
                    end
                end
                default: begin
                    s_d.st  = ST_IDLE;
                    s_d.txd = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.st  <= ST_IDLE;
            s_q.txd <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy = (s_q.st != ST_IDLE);
    assign txd  = s_q.txd;

    // R1: the line only moves on a tick edge
    p_line_moves_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) |-> $stable(s_q.txd));

    // R1: while idle or in the stop slot the line is high
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_IDLE || s_q.st == ST_STOP) |-> s_q.txd);

    // R3: a frame leaves the stop slot straight into a start bit when data waits
    p_back_to_back_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && s_q.st == ST_STOP && hold_full) |=> (s_q.st == ST_START && !s_q.txd));

endmodule

// File: rtl/dbt_brk.sv
module dbt_brk #(
    parameter int BRK_LEN = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rx_line,
    input  logic clr,
    output logic flag
);

    localparam int CW = $clog2(BRK_LEN + 1);
    localparam logic [CW-1:0] FINAL_CNT = CW'(BRK_LEN - 1);
    localparam logic [CW-1:0] SAT_CNT   = CW'(BRK_LEN);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          armed;
        logic          flag;
    } brk_s;

    brk_s b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (clr) begin
            b_d.flag = 1'b0;
        end
        if (tick) begin
            if (rx_line) begin
                b_d.cnt   = '0;
                b_d.armed = 1'b1;
            end else begin
                if (b_q.cnt != SAT_CNT) begin
                    b_d.cnt = b_q.cnt + 1'b1;
                end
                if (b_q.cnt == FINAL_CNT && b_q.armed) begin
                    b_d.flag  = 1'b1;
                    b_d.armed = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_q       <= '0;
            b_q.armed <= 1'b1;
        end else begin
            b_q <= b_d;
        end
    end

    assign flag = b_q.flag;

    // R10: the flag only rises on a tick that sampled the line low
    p_brk_rise_on_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(b_q.flag) |-> $past(tick && !rx_line));

    // R11: a clear with the line high always leaves the flag down
    p_brk_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && rx_line) |=> !b_q.flag);

endmodule

// File: rtl/dbuf_uart_tx.sv
module dbuf_uart_tx
    import dbuf_uart_pkg::*;
#(
    parameter int DATA_W    = DEF_DATA_W,
    parameter int BREAK_LEN = DEF_BREAK_LEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic [1:0]        mode_sel,
    input  logic              dbuf_en,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              bit9_in,
    input  logic              irq_clr,
    input  logic              ovr_clr,
    input  logic              brk_clr,
    input  logic              rx_line,
    output logic              txd,
    output logic              tx_irq,
    output logic              tx_ovr,
    output logic              brk_flag
);

    typedef struct packed {
        logic irq;
    } top_s;

    top_s t_d, t_q;

    logic              dbuf_eff;
    logic              nine_mode;
    logic              take;
    logic              busy;
    logic              stop_entry;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              hold_ninth;
    logic              irq_set;

    assign dbuf_eff  = dbuf_en && (mode_sel != MODE_SHIFT);
    assign nine_mode = mode_sel[1];

    dbt_hold #(.DW(DATA_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb),
        .wr_data  (wr_data),
        .ninth_in (bit9_in),
        .dbuf_on  (dbuf_eff),
        .busy     (busy),
        .take     (take),
        .ovr_clr  (ovr_clr),
        .full     (hold_full),
        .data     (hold_data),
        .ninth    (hold_ninth),
        .ovr      (tx_ovr)
    );

    dbt_shift #(.DW(DATA_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (baud_tick),
        .hold_full  (hold_full),
        .hold_data  (hold_data),
        .hold_ninth (hold_ninth),
        .ninth_live (bit9_in),
        .nine_mode  (nine_mode),
        .dbuf_on    (dbuf_eff),
        .take       (take),
        .busy       (busy),
        .stop_entry (stop_entry),
        .txd        (txd)
    );

    dbt_brk #(.BRK_LEN(BREAK_LEN)) u_brk (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (baud_tick),
        .rx_line (rx_line),
        .clr     (brk_clr),
        .flag    (brk_flag)
    );

    always_comb begin
        t_d     = t_q;
        irq_set = dbuf_eff ? take : stop_entry;
        if (irq_set) begin
            t_d.irq = 1'b1;
        end else if (irq_clr) begin
            t_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign tx_irq = t_q.irq;

    // R4: buffered mode signals as soon as the holding slot drains
    p_irq_on_drain_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && dbuf_eff) |=> tx_irq);

    // R7: single-buffered mode signals when the stop bit begins
    p_irq_on_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_entry && !dbuf_eff) |=> (tx_irq && txd));

    // R9: shift-mode selection refuses a write while a frame is out
    p_shift_mode_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == MODE_SHIFT && busy && wr_stb) |=> tx_ovr);

endmodule

// File: tb/sim_dbuf_uart_tx.sv
module sim_dbuf_uart_tx;

    localparam int DIV = 8;
    localparam int LOGN = 8192;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic [1:0] mode_sel = 2'b01;
    logic       dbuf_en = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = '0;
    logic       bit9_in = 1'b0;
    logic       irq_clr = 1'b0;
    logic       ovr_clr = 1'b0;
    logic       brk_clr = 1'b0;
    logic       rx_line = 1'b1;
    logic       txd, tx_irq, tx_ovr, brk_flag;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;
    int tcnt = 0;
    int bidx = 0;
    logic txlog [LOGN];
    logic irqlog [LOGN];

    dbuf_uart_tx u0 (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .mode_sel(mode_sel),
        .dbuf_en(dbuf_en), .wr_stb(wr_stb), .wr_data(wr_data), .bit9_in(bit9_in),
        .irq_clr(irq_clr), .ovr_clr(ovr_clr), .brk_clr(brk_clr), .rx_line(rx_line),
        .txd(txd), .tx_irq(tx_irq), .tx_ovr(tx_ovr), .brk_flag(brk_flag)
    );

    always #2 clk = ~clk;

    // tick generator and line logger: log the slot value set by each tick edge
    always @(negedge clk) begin
        if (baud_tick && bidx < LOGN) begin
            txlog[bidx]  = txd;
            irqlog[bidx] = tx_irq;
            bidx++;
        end
        tcnt = (tcnt == DIV - 1) ? 0 : tcnt + 1;
        baud_tick = (tcnt == 0);
    end

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (n * DIV) @(negedge clk);
    endtask

    task automatic write_byte(input logic [7:0] d, input logic b9);
        @(negedge clk);
        wr_data = d;
        bit9_in = b9;
        wr_stb  = 1'b1;
        @(negedge clk);
        wr_stb  = 1'b0;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) irq_clr = 1'b1;
        if (which == 1) ovr_clr = 1'b1;
        if (which == 2) brk_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        ovr_clr = 1'b0;
        brk_clr = 1'b0;
    endtask

    task automatic wait_irq();
        for (int i = 0; i < 4 * DIV && !tx_irq; i++) @(negedge clk);
    endtask

    task automatic find_frame(input int from, input bit nine, output int st,
                              output logic [8:0] v, output logic sb);
        st = -1;
        v  = '0;
        sb = 1'bx;
        for (int i = from; i < bidx; i++) begin
            if (txlog[i] === 1'b0) begin
                st = i;
                break;
            end
        end
        if (st >= 0 && st + 10 + int'(nine) < bidx) begin
            for (int k = 0; k < 8; k++) v[k] = txlog[st + 1 + k];
            if (nine) v[8] = txlog[st + 9];
            sb = txlog[st + 9 + int'(nine)];
        end
    endtask

    function automatic int zeros_from(input int from);
        int z = 0;
        for (int i = from; i < bidx; i++) if (txlog[i] === 1'b0) z++;
        return z;
    endfunction

    task automatic t_reset();
        chk("R12 txd", int'(txd), 1);
        chk("R12 tx_irq", int'(tx_irq), 0);
        chk("R12 tx_ovr", int'(tx_ovr), 0);
        chk("R12 brk_flag", int'(brk_flag), 0);
    endtask

    task automatic t_basic8();
        int s, st; logic [8:0] v; logic sb;
        mode_sel = 2'b01; dbuf_en = 1'b0;
        s = bidx;
        write_byte(8'hA5, 1'b0);
        wait_ticks(14);
        find_frame(s, 0, st, v, sb);
        chk("R1 data", int'(v[7:0]), 'hA5);
        chk("R1 stop", int'(sb), 1);
        chk("R1 idle after stop", zeros_from(st + 10), 0);
        pulse(0);
    endtask

    task automatic t_nine();
        int s, st; logic [8:0] v; logic sb;
        mode_sel = 2'b10; dbuf_en = 1'b1;
        s = bidx;
        write_byte(8'h3C, 1'b1);
        wait_ticks(15);
        find_frame(s, 1, st, v, sb);
        chk("R2 data", int'(v[7:0]), 'h3C);
        chk("R2 ninth", int'(v[8]), 1);
        chk("R2 stop", int'(sb), 1);
        bit9_in = 1'b0;
        pulse(0);
    endtask

    task automatic t_back_to_back();
        int s, st1, st2; logic [8:0] v1, v2; logic sb;
        mode_sel = 2'b01; dbuf_en = 1'b1;
        pulse(0);
        s = bidx;
        write_byte(8'h11, 1'b0);
        wait_irq();
        chk("R4 irq after drain", int'(tx_irq), 1);
        pulse(0);
        write_byte(8'h22, 1'b0);
        wait_ticks(25);
        find_frame(s, 0, st1, v1, sb);
        chk("R4 irq at start slot", int'(irqlog[st1]), 1);
        chk("R3 first", int'(v1[7:0]), 'h11);
        find_frame(st1 + 10, 0, st2, v2, sb);
        chk("R3 gap one stop", st2 - st1, 10);
        chk("R3 second", int'(v2[7:0]), 'h22);
        chk("R3 no overrun", int'(tx_ovr), 0);
        pulse(0);
    endtask

    task automatic t_nine_latched();
        int s, st; logic [8:0] v; logic sb;
        mode_sel = 2'b11; dbuf_en = 1'b1;
        s = bidx;
        write_byte(8'h5A, 1'b0);
        bit9_in = 1'b1;
        wait_ticks(15);
        find_frame(s, 1, st, v, sb);
        chk("R5 data", int'(v[7:0]), 'h5A);
        chk("R5 ninth latched", int'(v[8]), 0);
        bit9_in = 1'b0;
        pulse(0);
    endtask

    task automatic t_nine_live();
        int s, st; logic [8:0] v; logic sb;
        mode_sel = 2'b10; dbuf_en = 1'b0;
        s = bidx;
        write_byte(8'h5A, 1'b0);
        bit9_in = 1'b1;
        wait_ticks(15);
        find_frame(s, 1, st, v, sb);
        chk("R6 ninth live", int'(v[8]), 1);
        bit9_in = 1'b0;
        pulse(0);
    endtask

    task automatic t_single_irq();
        int s, st; logic [8:0] v; logic sb;
        mode_sel = 2'b01; dbuf_en = 1'b0;
        pulse(0);
        s = bidx;
        write_byte(8'h81, 1'b0);
        wait_ticks(14);
        find_frame(s, 0, st, v, sb);
        chk("R7 irq low at start", int'(irqlog[st]), 0);
        chk("R7 irq low in bit7", int'(irqlog[st + 8]), 0);
        chk("R7 irq at stop", int'(irqlog[st + 9]), 1);
        chk("R7 irq sticky", int'(tx_irq), 1);
        pulse(0);
        chk("R7 irq cleared", int'(tx_irq), 0);
    endtask

    task automatic t_overrun_dbuf();
        int s, st1, st2; logic [8:0] v; logic sb;
        mode_sel = 2'b01; dbuf_en = 1'b1;
        pulse(1);
        s = bidx;
        write_byte(8'h01, 1'b0);
        wait_irq();
        write_byte(8'h02, 1'b0);
        write_byte(8'h03, 1'b0);
        chk("R8 ovr set buffered", int'(tx_ovr), 1);
        wait_ticks(30);
        find_frame(s, 0, st1, v, sb);
        chk("R8 first", int'(v[7:0]), 'h01);
        find_frame(st1 + 10, 0, st2, v, sb);
        chk("R8 second", int'(v[7:0]), 'h02);
        chk("R8 dropped not sent", zeros_from(st2 + 10), 0);
        pulse(1);
        chk("R8 ovr cleared", int'(tx_ovr), 0);
        pulse(0);
    endtask

    task automatic t_overrun_single();
        int s, st; logic [8:0] v; logic sb;
        mode_sel = 2'b01; dbuf_en = 1'b0;
        s = bidx;
        write_byte(8'h44, 1'b0);
        wait_ticks(3);
        write_byte(8'h55, 1'b0);
        chk("R8 ovr set single", int'(tx_ovr), 1);
        wait_ticks(14);
        find_frame(s, 0, st, v, sb);
        chk("R8 single kept", int'(v[7:0]), 'h44);
        chk("R8 single dropped", zeros_from(st + 10), 0);
        pulse(1);
        pulse(0);
    endtask

    task automatic t_shift_mode();
        int s, st; logic [8:0] v; logic sb;
        mode_sel = 2'b00; dbuf_en = 1'b1;
        pulse(0);
        s = bidx;
        write_byte(8'h66, 1'b0);
        wait_ticks(3);
        write_byte(8'h77, 1'b0);
        chk("R9 write refused", int'(tx_ovr), 1);
        wait_ticks(14);
        find_frame(s, 0, st, v, sb);
        chk("R9 irq not at start", int'(irqlog[st]), 0);
        chk("R9 irq at stop", int'(irqlog[st + 9]), 1);
        chk("R9 data", int'(v[7:0]), 'h66);
        pulse(1);
        pulse(0);
    endtask

    task automatic t_break();
        @(negedge clk);
        rx_line = 1'b0;
        repeat (10 * DIV) @(negedge clk);
        rx_line = 1'b1;
        wait_ticks(2);
        chk("R10 ten lows no break", int'(brk_flag), 0);
        rx_line = 1'b0;
        repeat (11 * DIV) @(negedge clk);
        chk("R10 eleven lows break", int'(brk_flag), 1);
        pulse(2);
        chk("R11 cleared", int'(brk_flag), 0);
        wait_ticks(12);
        chk("R11 no reset while low", int'(brk_flag), 0);
        rx_line = 1'b1;
        wait_ticks(2);
        rx_line = 1'b0;
        repeat (11 * DIV) @(negedge clk);
        chk("R11 rearmed after high", int'(brk_flag), 1);
        rx_line = 1'b1;
        wait_ticks(1);
        pulse(2);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic8();
        t_nine();
        t_back_to_back();
        t_nine_latched();
        t_nine_live();
        t_single_irq();
        t_overrun_dbuf();
        t_overrun_single();
        t_shift_mode();
        t_break();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

endmodule